// File: doc/BRIEF.md
# Thresholded Event Tally Counter

This block accumulates a per-cycle event occurrence count, which may be larger than one, into a wide counter. A configuration register chooses how each cycle contributes. In summing mode (threshold zero) the full occurrence count of the cycle is added. In threshold mode (threshold nonzero) each qualifying cycle adds one. A cycle qualifies when its count is at or above the threshold, or below it when the comparison is inverted. An optional edge mode counts only the cycles where qualification turns from false to true.

The counter can be loaded directly. When the counter wraps, a sticky overflow flag is set, and only an explicit clear pulse clears it. The occurrence source sits outside the block, and so does any register access logic: loads, clears and configuration writes arrive as single-cycle strobes.

Top module: `evt_tally_ctr`

## Requirements
- R1: After reset the counter reads 0, the overflow flag reads 0, and the configuration is all zero (disabled, threshold 0, invert off, edge off).
- R2: When enabled with threshold 0, the occurrence count `evt_cnt` (0 to 15) of a cycle is added to the counter, and the sum is visible one clock later.
- R3: When enabled with threshold n > 0 and invert off, the counter gains exactly 1 in each cycle with `evt_cnt >= n`. In any other cycle it is unchanged.
- R4: When enabled with threshold n > 0 and invert on, the counter gains 1 in each cycle with `evt_cnt < n`. With n = 1 this counts cycles with zero occurrences.
- R5: With threshold 0 the invert bit has no effect: the raw occurrence count is still added.
- R6: With edge on and threshold n > 0, the counter gains 1 only in an enabled cycle that qualifies when the previous enabled cycle did not. With threshold 0 the edge bit has no effect.
- R7: The edge history is the previous cycle's qualification result while enabled, and is forced to "not qualified" in every disabled cycle. The first qualifying cycle after enable therefore counts as an edge.
- R8: While disabled the counter holds its value whatever `evt_cnt` is.
- R9: A counter load (`ld_en`) replaces the value with `ld_value` one clock later and wins over any increment in the same cycle.
- R10: A carry out of the top counter bit sets `ovf_flag`. The flag stays set until an `ovf_clr` pulse clears it. If a wrap and a clear fall in the same cycle, the flag ends set.
- R11: A configuration write (`cfg_we`) takes effect for the cycle after the write. The cycle of the write is still handled with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thresh | input | 4 | Threshold field (0 = summing mode) |
| cfg_inv | input | 1 | Invert the threshold comparison |
| cfg_edge | input | 1 | Count only rising edges of qualification |
| cfg_en | input | 1 | Counting enable |
| evt_cnt | input | 4 | Event occurrences in this cycle |
| ld_en | input | 1 | Counter load strobe |
| ld_value | input | 40 | Value to load |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| cnt_value | output | 40 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can fall in the same cycle. A load can coincide with an increment, and a wrap can coincide with an overflow clear. The bench drives a nonzero occurrence count while pulsing `ld_en`, and expects exactly the loaded value afterwards. It then loads the all-ones value and applies one occurrence together with `ovf_clr`, and expects a counter of zero with the flag still set. A separate test with the clear alone shows that the flag can be cleared.

// File: rtl/evt_tally_pkg.sv
package evt_tally_pkg;

  // Qualification of one cycle: summing mode always qualifies,
  // threshold mode compares (>= or, inverted, <).
  function automatic bit f_qualify(int unsigned evt, int unsigned thr, bit inv);
    if (thr == 0) return 1'b1;
    return inv ? (evt < thr) : (evt >= thr);
  endfunction

  // Amount added in one enabled cycle.
  function automatic int unsigned f_amount(int unsigned evt, int unsigned thr,
                                           bit qual, bit edge_on, bit prev);
    if (thr == 0) return evt;
    if (edge_on) return (qual && !prev) ? 1 : 0;
    return qual ? 1 : 0;
  endfunction

endpackage

// File: rtl/evt_tally_cfg.sv
module evt_tally_cfg #(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [THR_W-1:0] thresh_in,
  input  logic             inv_in,
  input  logic             edge_in,
  input  logic             en_in,
  output logic [THR_W-1:0] thresh,
  output logic             inv,
  output logic             edge_on,
  output logic             en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh  <= '0;
      inv     <= 1'b0;
      edge_on <= 1'b0;
      en      <= 1'b0;
    end else if (we) begin
      thresh  <= thresh_in;
      inv     <= inv_in;
      edge_on <= edge_in;
      en      <= en_in;
    end
  end
endmodule

// File: rtl/evt_tally_qual.sv
module evt_tally_qual
  import evt_tally_pkg::*;
#(
  parameter int EVT_W = 4,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [THR_W-1:0] thresh,
  input  logic             inv,
  input  logic             edge_on,
  input  logic [EVT_W-1:0] evt,
  output logic [EVT_W-1:0] inc
);
  logic qual_now;
  logic prev_q;
  logic thr_nz;

  assign thr_nz   = (thresh != '0);
  assign qual_now = f_qualify(32'(evt), 32'(thresh), inv);

  always_comb begin
    inc = '0;
    if (en) inc = EVT_W'(f_amount(32'(evt), 32'(thresh), qual_now, edge_on, prev_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_q <= 1'b0;
    else if (en)  prev_q <= qual_now;
    else          prev_q <= 1'b0;
  end

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_nz |-> (inc <= EVT_W'(1)));
  // R6
  edge_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_on && thr_nz && prev_q) |-> (inc == '0));
  // R7
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !prev_q);
endmodule

// File: rtl/evt_tally_accum.sv
module evt_tally_accum #(
  parameter int EVT_W = 4,
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [EVT_W-1:0] inc,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_value,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;
  logic             wrap_evt;

  assign sum      = {1'b0, cnt} + SUM_W'(inc);
  assign wrap_evt = en && !ld_en && sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (ld_en)  cnt <= ld_value;
    else if (en)     cnt <= sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf <= 1'b0;
    else if (wrap_evt)  ovf <= 1'b1;
    else if (ovf_clr)   ovf <= 1'b0;
  end

  // R9
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (cnt == $past(ld_value)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld_en) |=> $stable(cnt));
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R10
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld_en && (&cnt) && (inc != '0)) |=> ovf);
endmodule

// File: rtl/evt_tally_ctr.sv
module evt_tally_ctr #(
  parameter int EVT_W = 4,
  parameter int THR_W = 4,
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [THR_W-1:0] cfg_thresh,
  input  logic             cfg_inv,
  input  logic             cfg_edge,
  input  logic             cfg_en,
  input  logic [EVT_W-1:0] evt_cnt,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_value,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_value,
  output logic             ovf_flag
);
  logic [THR_W-1:0] thresh;
  logic             inv, edge_on, en;
  logic [EVT_W-1:0] inc_amt;

  evt_tally_cfg #(.THR_W(THR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .thresh_in(cfg_thresh), .inv_in(cfg_inv), .edge_in(cfg_edge), .en_in(cfg_en),
    .thresh(thresh), .inv(inv), .edge_on(edge_on), .en(en)
  );

  evt_tally_qual #(.EVT_W(EVT_W), .THR_W(THR_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .en(en), .thresh(thresh), .inv(inv),
    .edge_on(edge_on), .evt(evt_cnt), .inc(inc_amt)
  );

  evt_tally_accum #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(en), .inc(inc_amt),
    .ld_en(ld_en), .ld_value(ld_value), .ovf_clr(ovf_clr),
    .cnt(cnt_value), .ovf(ovf_flag)
  );

  // R5
  inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && thresh == '0 && !ld_en && !cnt_value[CNT_W-1]) |=>
      (cnt_value == $past(cnt_value) + CNT_W'($past(evt_cnt))));
endmodule

// File: tb/evt_tally_ctr_bench.sv
module evt_tally_ctr_bench;
  localparam int CW = 40;

  typedef struct {
    logic [CW-1:0] cnt;
    logic          ovf;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 0, cfg_inv = 0, cfg_edge = 0, cfg_en = 0;
  logic [3:0]    cfg_thresh = 0, evt_cnt = 0;
  logic          ld_en = 0, ovf_clr = 0;
  logic [CW-1:0] ld_value = 0;
  logic [CW-1:0] cnt_value;
  logic          ovf_flag;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  // model state
  logic [CW-1:0] m_cnt = 0;
  logic m_ovf = 0, m_prev = 0, m_inv = 0, m_edge = 0, m_en = 0;
  logic [3:0] m_thr = 0;

  always #5 clk = ~clk;

  evt_tally_ctr u_evt_tally_ctr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
    .cfg_inv(cfg_inv), .cfg_edge(cfg_edge), .cfg_en(cfg_en), .evt_cnt(evt_cnt),
    .ld_en(ld_en), .ld_value(ld_value), .ovf_clr(ovf_clr),
    .cnt_value(cnt_value), .ovf_flag(ovf_flag)
  );

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cnt_value !== e.cnt || ovf_flag !== e.ovf) begin
        errors++;
        $display("FAIL %s: cnt=%0d ovf=%0b expected cnt=%0d ovf=%0b",
                 e.req, cnt_value, ovf_flag, e.cnt, e.ovf);
      end
    end
  end

  // driver: one clock with the current inputs, expected result queued
  task automatic tick(input string req);
    logic qual, wrap;
    logic [CW:0] s;
    int unsigned add;
    exp_t e;
    if (m_thr == 0) qual = 1'b1;
    else qual = m_inv ? (evt_cnt < m_thr) : (evt_cnt >= m_thr);
    add = 0;
    if (m_en) begin
      if (m_thr == 0) add = evt_cnt;
      else if (m_edge) add = (qual && !m_prev) ? 1 : 0;
      else add = qual ? 1 : 0;
    end
    s = {1'b0, m_cnt} + (CW+1)'(add);
    wrap = m_en && !ld_en && s[CW];
    if (ld_en) m_cnt = ld_value; else m_cnt = s[CW-1:0];
    if (wrap) m_ovf = 1'b1; else if (ovf_clr) m_ovf = 1'b0;
    m_prev = m_en ? qual : 1'b0;
    if (cfg_we) begin
      m_thr = cfg_thresh; m_inv = cfg_inv; m_edge = cfg_edge; m_en = cfg_en;
    end
    e.cnt = m_cnt; e.ovf = m_ovf; e.req = req;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; ld_en = 0; ovf_clr = 0;
  endtask

  task automatic setcfg(input logic [3:0] t, input logic i, input logic ed,
                        input logic en, input string req);
    cfg_we = 1; cfg_thresh = t; cfg_inv = i; cfg_edge = ed; cfg_en = en;
    evt_cnt = 0;
    tick(req);
  endtask

  task automatic ev(input logic [3:0] v, input string req);
    evt_cnt = v;
    tick(req);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (cnt_value !== '0 || ovf_flag !== 1'b0) begin
      errors++;
      $display("FAIL R1: cnt=%0d ovf=%0b expected cnt=0 ovf=0", cnt_value, ovf_flag);
    end
    ev(4'd9, "R1_R8 disabled after reset");
    // R2 summing mode
    setcfg(4'd0, 0, 0, 1, "R2 cfg");
    ev(4'd3, "R2"); ev(4'd15, "R2"); ev(4'd0, "R2"); ev(4'd7, "R2");
    // R5 invert ignored with zero threshold, R6 edge ignored too
    setcfg(4'd0, 1, 1, 1, "R5 cfg");
    ev(4'd2, "R5"); ev(4'd5, "R5"); ev(4'd5, "R6 edge ignored at thr0");
    // R3 threshold
    setcfg(4'd3, 0, 0, 1, "R3 cfg");
    ev(4'd2, "R3"); ev(4'd3, "R3"); ev(4'd9, "R3"); ev(4'd0, "R3"); ev(4'd15, "R3");
    // R4 inverted, stall cycles
    setcfg(4'd1, 1, 0, 1, "R4 cfg");
    ev(4'd0, "R4"); ev(4'd4, "R4"); ev(4'd0, "R4"); ev(4'd0, "R4");
    // R6 edge
    setcfg(4'd2, 0, 1, 1, "R6 cfg");
    ev(4'd5, "R6"); ev(4'd5, "R6"); ev(4'd0, "R6"); ev(4'd3, "R6"); ev(4'd3, "R6");
    // R8 disabled, R7 history cleared
    setcfg(4'd2, 0, 1, 0, "R8 cfg");
    ev(4'd5, "R8"); ev(4'd12, "R8");
    setcfg(4'd2, 0, 1, 1, "R7 cfg");
    ev(4'd5, "R7 first after enable"); ev(4'd5, "R7");
    // R11 config write cycle uses old settings
    setcfg(4'd0, 0, 0, 1, "R11 cfg");
    evt_cnt = 4'd2; cfg_we = 1; cfg_thresh = 4'd4; cfg_inv = 0; cfg_edge = 0; cfg_en = 1;
    tick("R11 old cfg applies");
    ev(4'd2, "R11 new cfg applies"); ev(4'd6, "R11");
    // R9 load beats increment
    setcfg(4'd0, 0, 0, 1, "R9 cfg");
    evt_cnt = 4'd4; ld_en = 1; ld_value = 40'd100;
    tick("R9");
    ev(4'd1, "R9 after load");
    // R10 wrap
    evt_cnt = 4'd0; ld_en = 1; ld_value = {CW{1'b1}} - 40'd2;
    tick("R10 load");
    ev(4'd5, "R10 wrap"); ev(4'd1, "R10 sticky");
    evt_cnt = 4'd0; ovf_clr = 1; tick("R10 clear");
    evt_cnt = 4'd0; ld_en = 1; ld_value = {CW{1'b1}}; tick("R10 load");
    evt_cnt = 4'd1; ovf_clr = 1; tick("R10 wrap beats clear");
    ev(4'd0, "R10");
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule